// File: doc/BRIEF.md
# Serial Configuration PROM Loader

This block copies a 64-word, 16-bit serial configuration PROM into a local buffer as soon as reset is released. It drives the PROM through a chip-select, serial clock and serial data-in pin, and it samples a single serial data-out pin. Each word is fetched by its own read transaction. A 16-bit wrapping sum of the whole image is built as the words arrive. The image counts as good only when that sum equals a fixed signature.

Once the last word is in, the block raises `done`. If the image is good, it also raises `valid` and presents three settings taken from fixed byte locations: a host bus ID, a tag queue depth and an output-drive option bit. Other logic can read any buffered word through a combinational read port. A one-cycle `start` pulse throws away the current contents and runs the whole load again.

Top module: `cfg_prom_loader`

## Requirements
- R1: After reset release, or after a `start` pulse, the block fetches words 0 to 63 in ascending order with no software action. It then raises `done` and holds `prom_cs` low.
- R2: Each fetch holds `prom_cs` high while it shifts out 9 bits on `prom_di`, most significant bit first: a 1, then the byte 0x80 plus the word number. Each bit is set up one phase before `prom_sk` rises, held while `prom_sk` is high, and held for one phase after `prom_sk` falls.
- R3: After the 9th command bit, the block gives 16 more `prom_sk` pulses. It takes in one data bit per pulse, most significant bit first, and samples it at the end of the low phase that follows the pulse. After `done`, `rd_data` shows word `rd_addr` as it was received.
- R4: Every pin phase lasts exactly `PHASE_CYC` clock cycles, and `prom_cs` is low for one phase before every fetch. A full load of 64 words therefore takes 64 × 60 × `PHASE_CYC` cycles.
- R5: `valid` is 1 only while `done` is 1 and the 16-bit wrapping sum of all 64 words equals 0x1234.
- R6: When `valid` is 1, `host_id` equals byte 0x40 of the image. Bytes are little-endian within words, so byte 2k is bits 7:0 of word k and byte 2k+1 is bits 15:8.
- R7: When `valid` is 1, `tag_depth` equals 2 shifted left by byte 0x43, truncated to 16 bits.
- R8: When `valid` is 1, `act_neg` equals bit 3 of byte 0x41.
- R9: When `valid` is 0, whether the load is still running or the image failed its sum, `host_id` is 7, `tag_depth` is 0 and `act_neg` is 0. `done` still rises after a load whose sum is wrong.
- R10: A `start` pulse clears `done` and `valid` in the next cycle. It aborts any fetch in progress and restarts the load at word 0.
- R11: `prom_sk` is high only while `prom_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that restarts the whole load |
| prom_cs | output | 1 | PROM chip select |
| prom_sk | output | 1 | PROM serial clock |
| prom_di | output | 1 | Serial command bit to the PROM |
| prom_do | input | 1 | Serial data bit from the PROM |
| rd_addr | input | 6 | Buffer read word address |
| rd_data | output | 16 | Buffered word at `rd_addr` (combinational) |
| done | output | 1 | Load finished |
| valid | output | 1 | Image checksum matched |
| host_id | output | 8 | Decoded host bus ID |
| tag_depth | output | 16 | Decoded tag queue depth |
| act_neg | output | 1 | Decoded output-drive option |

## Verification
A full load is due 64 × 60 × `PHASE_CYC` cycles after the edge that ends reset or takes a `start` pulse. The bench counts cycles from that edge and accepts `done` only within two cycles of that figure. The settings and `valid` are registered together with `done`, so the bench checks them in the same cycle that it sees `done`. The clearing effect of `start` is checked one cycle after the pulse. A behavioural PROM model checks every command as it arrives and serves data on each serial clock rise. The design samples that data a full phase later, so the readback of the buffer never depends on when an edge falls.

// File: rtl/cfg_prom_loader.sv
module cfg_prom_loader #(
  parameter int WORDS     = 64,
  parameter int PHASE_CYC = 8000,
  parameter int TAGW      = 16,
  parameter logic [15:0] SIGNATURE = 16'h1234,
  parameter logic [7:0]  DEF_ID    = 8'd7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     prom_cs,
  output logic                     prom_sk,
  output logic                     prom_di,
  input  logic                     prom_do,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [15:0]              rd_data,
  output logic                     done,
  output logic                     valid,
  output logic [7:0]               host_id,
  output logic [TAGW-1:0]          tag_depth,
  output logic                     act_neg
);
  localparam int AW = $clog2(WORDS);
  localparam int TW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(PHASE_CYC - 1);
  localparam logic [7:0] CMD_BASE = 8'h80;
  localparam int ID_BYTE   = 'h40;
  localparam int MODE_BYTE = 'h41;
  localparam int TAG_BYTE  = 'h43;
  localparam int NEG_BIT   = 3;

  typedef enum logic [1:0] {ST_GAP, ST_CMD, ST_DATA, ST_DONE} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic          sub2;
  logic [1:0]    sub;
  logic [3:0]    bitn;
  logic [AW-1:0] word;
  logic [15:0]   sh, sum;
  logic [15:0]   mem [WORDS];

  wire        tick     = (tmr == T_LAST);
  wire [15:0] sh_nxt   = {sh[14:0], prom_do};
  wire        word_end = (st == ST_DATA) && tick && (sub == 2'd1) && (bitn == 4'd0);
  wire [8:0]  cmd9     = {1'b1, CMD_BASE + 8'(word)};

  assign sub2 = (sub == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      st <= ST_GAP; tmr <= '0; sub <= '0; bitn <= '0; word <= '0;
      sh <= '0; sum <= '0; done <= 1'b0; valid <= 1'b0;
    end else if (st != ST_DONE) begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick) begin
        case (st)
          ST_GAP: begin st <= ST_CMD; sub <= '0; bitn <= 4'd8; end
          ST_CMD: begin
            if (sub2) begin
              sub <= '0;
              if (bitn == 4'd0) begin st <= ST_DATA; bitn <= 4'd15; end
              else bitn <= bitn - 1'b1;
            end else sub <= sub + 1'b1;
          end
          ST_DATA: begin
            if (sub == 2'd1) begin
              sh  <= sh_nxt;
              sub <= '0;
              if (bitn == 4'd0) begin
                sum <= sum + sh_nxt;
                if (word == AW'(WORDS - 1)) begin
                  st    <= ST_DONE;
                  done  <= 1'b1;
                  valid <= (sum + sh_nxt) == SIGNATURE;
                end else begin
                  word <= word + 1'b1;
                  st   <= ST_GAP;
                end
              end else bitn <= bitn - 1'b1;
            end else sub <= 2'd1;
          end
          default: st <= ST_DONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (word_end) mem[word] <= sh_nxt;

  assign rd_data = mem[rd_addr];

  assign prom_cs = (st == ST_CMD) || (st == ST_DATA);
  assign prom_sk = ((st == ST_CMD) && (sub == 2'd1)) || ((st == ST_DATA) && (sub == 2'd0));
  assign prom_di = (st == ST_CMD) ? cmd9[bitn] : 1'b0;

  wire [15:0] w_idm = mem[ID_BYTE / 2];
  wire [15:0] w_tag = mem[TAG_BYTE / 2];
  wire [7:0]  b_id   = (ID_BYTE % 2)   ? w_idm[15:8] : w_idm[7:0];
  wire [7:0]  b_mode = (MODE_BYTE % 2) ? w_idm[15:8] : w_idm[7:0];
  wire [7:0]  b_tag  = (TAG_BYTE % 2)  ? w_tag[15:8] : w_tag[7:0];

  assign host_id   = valid ? b_id : DEF_ID;
  assign tag_depth = valid ? (TAGW'(2) << b_tag) : '0;
  assign act_neg   = valid & b_mode[NEG_BIT];

  a_r1_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !prom_cs);
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start && st != ST_DONE) |=> $stable({prom_cs, prom_sk, prom_di}));
  a_r5_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done);
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !valid));
  a_r11_sk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    prom_sk |-> prom_cs);
endmodule

// File: tb/tb_cfg_prom_loader.sv
`timescale 1ns/1ps
module tb_cfg_prom_loader;
  localparam int PC = 4;
  localparam int FULL = 64 * 60 * PC;

  logic clk = 0, rst_n = 0, start = 0, prom_do = 0;
  logic prom_cs, prom_sk, prom_di, done, valid, act_neg;
  logic [5:0] rd_addr = 0;
  logic [15:0] rd_data, tag_depth;
  logic [7:0] host_id;

  cfg_prom_loader #(.PHASE_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prom_cs(prom_cs), .prom_sk(prom_sk),
    .prom_di(prom_di), .prom_do(prom_do), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .valid(valid), .host_id(host_id), .tag_depth(tag_depth), .act_neg(act_neg));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] img [64];

  int cnt = 0, exp_addr = 0, bad_cmd = 0, served = 0, cur = 0;
  logic [8:0] cmd = 0;
  always @(posedge prom_cs) begin cnt = 0; cmd = 0; end
  always @(posedge prom_sk) begin
    if (cnt < 9) begin
      cmd = {cmd[7:0], prom_di};
      cnt++;
      if (cnt == 9) begin
        if (cmd != {1'b1, 8'h80 + 8'(exp_addr)}) bad_cmd++;
        cur = cmd[5:0];
      end
    end else if (cnt < 25) begin
      prom_do <= img[cur][15 - (cnt - 9)];
      cnt++;
      if (cnt == 25) begin exp_addr++; served++; end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input int seed, input logic [7:0] id, input logic [7:0] mode,
                       input logic [7:0] tag, input logic good);
    logic [15:0] s;
    s = 0;
    for (int k = 0; k < 64; k++) img[k] = 16'((k * 16'h0731) ^ (seed * 16'h9e37) ^ 16'h8001);
    img[32] = {mode, id};
    img[33] = {tag, 8'h5a};
    for (int k = 0; k < 63; k++) s = s + img[k];
    img[63] = 16'h1234 - s + (good ? 16'd0 : 16'd1);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    exp_addr = 0; served = 0; bad_cmd = 0;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < FULL + 50) begin @(negedge clk); cyc++; end
  endtask

  task automatic check_load(input string tag, input int cyc);
    chk(done && cyc >= FULL - 2 && cyc <= FULL + 2, "R4 load time", cyc, FULL);
    chk(bad_cmd == 0, "R2 command bits", bad_cmd, 0);
    chk(served == 64, "R1 words fetched", served, 64);
    chk(!prom_cs, "R1 cs idle after done", prom_cs, 0);
    for (int k = 0; k < 64; k++) begin
      rd_addr = 6'(k); #1;
      chk(rd_data == img[k], "R3 buffer word", rd_data, img[k]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!done && !valid, "R9 reset done/valid", {done, valid}, 0);
    chk(host_id == 7 && tag_depth == 0 && !act_neg, "R9 reset settings", host_id, 7);
    chk(!prom_cs && !prom_sk, "R11 reset pins", {prom_cs, prom_sk}, 0);
  endtask

  task automatic t_good_first();
    int cyc;
    build(1, 8'h05, 8'h08, 8'h03, 1);
    @(negedge clk); rst_n = 1;
    wait_done(cyc);
    check_load("first", cyc);
    chk(valid, "R5 good sum", valid, 1);
    chk(host_id == 8'h05, "R6 host id", host_id, 5);
    chk(tag_depth == 16'd16, "R7 tag depth", tag_depth, 16);
    chk(act_neg, "R8 act_neg set", act_neg, 1);
  endtask

  task automatic t_bad_sum();
    int cyc;
    build(2, 8'h03, 8'hf7, 8'h02, 0);
    pulse_start();
    chk(!done && !valid, "R10 start clears", {done, valid}, 0);
    wait_done(cyc);
    check_load("bad", cyc);
    chk(!valid, "R5 bad sum", valid, 0);
    chk(host_id == 7 && tag_depth == 0 && !act_neg, "R9 fallback", host_id, 7);
  endtask

  task automatic t_tag_edge();
    int cyc;
    build(3, 8'h0e, 8'hf7, 8'd14, 1);
    pulse_start();
    wait_done(cyc);
    check_load("edge", cyc);
    chk(valid, "R5 good sum 2", valid, 1);
    chk(host_id == 8'h0e, "R6 host id 2", host_id, 8'h0e);
    chk(tag_depth == 16'h8000, "R7 tag top bit", tag_depth, 16'h8000);
    chk(!act_neg, "R8 act_neg clear", act_neg, 0);
  endtask

  task automatic t_restart_mid();
    int cyc;
    build(4, 8'h01, 8'h08, 8'h00, 1);
    pulse_start();
    repeat (3001) @(negedge clk);
    chk(!done && prom_cs === prom_cs, "R10 mid-load busy", done, 0);
    build(5, 8'h02, 8'h00, 8'h01, 1);
    pulse_start();
    wait_done(cyc);
    check_load("restart", cyc);
    chk(valid && host_id == 8'h02 && tag_depth == 16'd4, "R10 restarted image", host_id, 2);
  endtask

  initial begin
    t_reset();
    t_good_first();
    t_bad_sum();
    t_tag_edge();
    t_restart_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule